// File: doc/BRIEF.md
# Hard Trap Conflict Detector

This block follows the hardware traps of a small processor core. Each trap source has one request line, and the sources are ranked by fixed priority. Oscillator failure is the most urgent, followed by address error, then stack error, then math error. Each source moves through its own three-phase life: waiting for the core, acknowledged, and in service. The block picks the most urgent active trap and reports that trap's vector slot. It holds execution stalled until the core acknowledges the trap.

A more urgent trap that arrives while a less urgent one is being handled is legal. It nests: it is served first, and afterwards the outer trap carries on. A less urgent trap that arrives while any more urgent trap is in any phase is a conflict. A conflict raises a device reset request, and that request stays high until the block's reset is applied. A conflict also sets a sticky cause flag. The flag survives that reset so that software can see it later. Software clears it with an explicit clear pulse, and a power-on reset also clears it.

Top module: `trap_conflict_unit`

## Requirements
- R1: A one-cycle pulse on `trap_req[i]` while the block is idle makes `stall` high and `vec_idx` equal to i+1 in the next cycle. The request bits are: bit 0 oscillator fail, bit 1 address error, bit 2 stack error, bit 3 math error. Slot 0 is the reset slot.
- R2: `stall` stays high for as long as the reported trap has not been acknowledged. In the cycle after `ack` is sampled, `stall` is low, provided no new request arrives.
- R3: When several traps are active, `vec_idx` names the one with the lowest request-bit index. This includes requests that arrive in the same cycle.
- R4: `ipl3` is high from the cycle after a trap is acknowledged until that trap completes. It is low whenever no trap is active.
- R5: A `done` pulse while the reported trap is acknowledged or in service returns that trap to idle in the next cycle.
- R6: A request on bit i while any bit j<i is active (waiting, acknowledged or in service) sets `rst_req` in the next cycle. `rst_req` then stays high until `rst`.
- R7: A request with a lower bit index than every active trap is not a conflict. It becomes the reported trap, with `stall` high. Once it completes, `vec_idx` returns to the outer trap, which is still in service, with `ipl3` high and `stall` low.
- R8: `conflict_flag` is set together with `rst_req`. It is unaffected by `rst`, and it is cleared by `flag_clr` or by `por`. If a conflict and `flag_clr` happen in the same cycle, the set wins.
- R9: A repeated request from a source that is already active is ignored. It causes no conflict and no change in `vec_idx`.
- R10: `ack` with no trap waiting has no effect, and `done` with no trap acknowledged has no effect.
- R11: `rst` returns every source to idle and clears `rst_req`. After it, `stall`, `ipl3` and `vec_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the trap tracking and the reset request |
| por | input | 1 | Power-on reset, which also clears the sticky flag |
| trap_req | input | NUM_TRAPS | One request pulse per trap source, bit 0 most urgent |
| ack | input | 1 | Core acknowledges the reported trap |
| done | input | 1 | Trap return completed for the reported trap |
| flag_clr | input | 1 | Software clear of the sticky conflict flag |
| stall | output | 1 | Execution held until acknowledge |
| vec_idx | output | VEC_W | Vector slot of the reported trap, 0 when idle |
| ipl3 | output | 1 | Trap priority bit, high while a trap is acknowledged or in service |
| rst_req | output | 1 | Device reset request after a conflict |
| conflict_flag | output | 1 | Sticky conflict cause flag |

## Verification
Each source is tried alone, so that its slot number, its stall window and its `ipl3` window are seen in isolation. Two requests in the same cycle test whether the priority pick is right without any nesting. An urgent request that lands during a less urgent trap's service separates nesting from conflict. The inverse order is then driven once in each of the three phases, to show that all three phases trip the reset request. Repeated requests, a stray `ack` and a stray `done` confirm that harmless events leave the state unchanged. The flag is then exercised on its own: it must survive `rst`, respond to its clear pulse, and win when a conflict and a clear arrive together.

// File: rtl/trap_conflict_pkg.sv
package trap_conflict_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ACKD = 2'd2,
        PH_SERV = 2'd3
    } trap_phase_e;

    function automatic logic phase_handled(trap_phase_e p);
        return (p == PH_ACKD) || (p == PH_SERV);
    endfunction

    function automatic logic phase_active(trap_phase_e p);
        return p != PH_IDLE;
    endfunction

endpackage

// File: rtl/trap_slot.sv
module trap_slot
    import trap_conflict_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        arm,
    input  logic        ack_hit,
    input  logic        done_hit,
    output trap_phase_e phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (arm)      phase <= PH_WAIT;
                PH_WAIT: if (ack_hit)  phase <= PH_ACKD;
                PH_ACKD: phase <= done_hit ? PH_IDLE : PH_SERV;
                PH_SERV: if (done_hit) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/trap_select.sv
module trap_select #(
    parameter int NUM_TRAPS = 4,
    localparam int IDX_W = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1
) (
    input  logic [NUM_TRAPS-1:0] busy,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_TRAPS - 1; i >= 0; i--) begin
            if (busy[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/trap_conflict_unit.sv
module trap_conflict_unit
    import trap_conflict_pkg::*;
#(
    parameter int NUM_TRAPS = 4,
    localparam int IDX_W = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1,
    localparam int VEC_W = $clog2(NUM_TRAPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por,
    input  logic [NUM_TRAPS-1:0] trap_req,
    input  logic                 ack,
    input  logic                 done,
    input  logic                 flag_clr,
    output logic                 stall,
    output logic [VEC_W-1:0]     vec_idx,
    output logic                 ipl3,
    output logic                 rst_req,
    output logic                 conflict_flag
);

    trap_phase_e            phase [NUM_TRAPS];
    logic [NUM_TRAPS-1:0]   busy;
    logic [NUM_TRAPS-1:0]   handled;
    logic [NUM_TRAPS-1:0]   above_busy;
    logic [NUM_TRAPS-1:0]   arm;
    logic [NUM_TRAPS-1:0]   ack_hit;
    logic [NUM_TRAPS-1:0]   done_hit;
    logic                   sel_any;
    logic [IDX_W-1:0]       sel_idx;
    logic                   clash;
    logic                   sel_waiting;
    logic                   sel_handled;

    // A source is blocked (and a request on it clashes) when any more urgent one is active
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < NUM_TRAPS; i++) begin
            busy[i]       = phase_active(phase[i]);
            handled[i]    = phase_handled(phase[i]);
            above_busy[i] = acc;
            acc           = acc | busy[i];
        end
    end

    assign clash = |(trap_req & above_busy);

    trap_select #(.NUM_TRAPS(NUM_TRAPS)) u_sel (
        .busy (busy),
        .any  (sel_any),
        .idx  (sel_idx)
    );

    assign sel_waiting = sel_any && (phase[sel_idx] == PH_WAIT);
    assign sel_handled = sel_any && phase_handled(phase[sel_idx]);

    generate
        for (genvar g = 0; g < NUM_TRAPS; g++) begin : g_slot
            assign arm[g]      = trap_req[g] && !above_busy[g] && !rst_req;
            assign ack_hit[g]  = ack  && sel_waiting && (sel_idx == IDX_W'(g));
            assign done_hit[g] = done && sel_handled && (sel_idx == IDX_W'(g));

            trap_slot u_slot (
                .clk      (clk),
                .rst      (rst),
                .arm      (arm[g]),
                .ack_hit  (ack_hit[g]),
                .done_hit (done_hit[g]),
                .phase    (phase[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
        end else if (clash) begin
            rst_req <= 1'b1;
        end
    end

    // Sticky cause: survives rst, only power-on or software clear it
    always_ff @(posedge clk) begin
        if (por) begin
            conflict_flag <= 1'b0;
        end else if (clash && !rst) begin
            conflict_flag <= 1'b1;
        end else if (flag_clr) begin
            conflict_flag <= 1'b0;
        end
    end

    assign stall   = sel_waiting;
    assign ipl3    = |handled;
    assign vec_idx = sel_any ? (VEC_W'(sel_idx) + VEC_W'(1)) : '0;

endmodule

// File: rtl/trap_conflict_chk.sv
module trap_conflict_chk #(
    parameter int NUM_TRAPS = 4,
    parameter int VEC_W = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 por,
    input logic [NUM_TRAPS-1:0] trap_req,
    input logic                 ack,
    input logic                 done,
    input logic                 flag_clr,
    input logic                 stall,
    input logic [VEC_W-1:0]     vec_idx,
    input logic                 ipl3,
    input logic                 rst_req,
    input logic                 conflict_flag
);

    assert_stall_has_vec_R1: assert property (@(posedge clk) disable iff (rst || por)
        stall |-> (vec_idx != '0));

    assert_ack_releases_R2: assert property (@(posedge clk) disable iff (rst || por)
        (stall && ack && trap_req == '0 && !done) |=> (!stall && ipl3));

    assert_ipl3_idle_R4: assert property (@(posedge clk) disable iff (rst || por)
        (vec_idx == '0) |-> !ipl3);

    assert_reset_req_hold_R6: assert property (@(posedge clk) disable iff (rst || por)
        rst_req |=> rst_req);

    assert_flag_with_req_R8: assert property (@(posedge clk) disable iff (rst || por)
        $rose(rst_req) |-> conflict_flag);

    assert_idle_stays_R10: assert property (@(posedge clk) disable iff (rst || por)
        (vec_idx == '0 && trap_req == '0) |=> (vec_idx == '0 && !stall));

endmodule

bind trap_conflict_unit trap_conflict_chk #(.NUM_TRAPS(NUM_TRAPS), .VEC_W(VEC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .por           (por),
    .trap_req      (trap_req),
    .ack           (ack),
    .done          (done),
    .flag_clr      (flag_clr),
    .stall         (stall),
    .vec_idx       (vec_idx),
    .ipl3          (ipl3),
    .rst_req       (rst_req),
    .conflict_flag (conflict_flag)
);

// File: tb/trap_conflict_unit_test.sv
module trap_conflict_unit_test;

    localparam int N = 4;
    localparam int VW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          por = 1'b1;
    logic [N-1:0]  trap_req = '0;
    logic          ack = 1'b0;
    logic          done = 1'b0;
    logic          flag_clr = 1'b0;
    logic          stall;
    logic [VW-1:0] vec_idx;
    logic          ipl3;
    logic          rst_req;
    logic          conflict_flag;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    trap_conflict_unit #(.NUM_TRAPS(N)) uut (
        .clk(clk), .rst(rst), .por(por), .trap_req(trap_req), .ack(ack),
        .done(done), .flag_clr(flag_clr), .stall(stall), .vec_idx(vec_idx),
        .ipl3(ipl3), .rst_req(rst_req), .conflict_flag(conflict_flag)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic pulse_req(logic [N-1:0] r);
        trap_req = r; tick(); trap_req = '0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_done();
        done = 1'b1; tick(); done = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(); rst = 1'b0;
    endtask

    task automatic t_reset();
        por = 1'b1; rst = 1'b1; tick(); tick(); por = 1'b0; rst = 1'b0;
        check("R11", "stall", stall, 0);
        check("R11", "vec_idx", vec_idx, 0);
        check("R11", "ipl3", ipl3, 0);
        check("R11", "rst_req", rst_req, 0);
        check("R8", "flag after por", conflict_flag, 0);
    endtask

    task automatic t_single(int i);
        pulse_req(N'(1) << i);
        check("R1", "stall", stall, 1);
        check("R1", "vec_idx", vec_idx, i + 1);
        tick();
        check("R2", "stall held", stall, 1);
        check("R4", "ipl3 before ack", ipl3, 0);
        pulse_ack();
        check("R2", "stall after ack", stall, 0);
        check("R4", "ipl3 after ack", ipl3, 1);
        tick();
        check("R4", "ipl3 in service", ipl3, 1);
        pulse_done();
        check("R5", "vec_idx after done", vec_idx, 0);
        check("R5", "ipl3 after done", ipl3, 0);
        check("R6", "no reset", rst_req, 0);
    endtask

    task automatic t_priority();
        pulse_req(4'b1010);
        check("R3", "vec pick", vec_idx, 2);
        check("R3", "no clash same cycle", rst_req, 0);
        pulse_ack();
        check("R3", "vec while served", vec_idx, 2);
        pulse_done();
        check("R3", "next waiting vec", vec_idx, 4);
        check("R3", "stall for next", stall, 1);
        pulse_ack();
        pulse_done();
        check("R5", "idle after both", vec_idx, 0);
    endtask

    task automatic t_nest();
        pulse_req(4'b1000);
        pulse_ack();
        tick();
        pulse_req(4'b0001);
        check("R7", "no reset on nest", rst_req, 0);
        check("R7", "stall nested", stall, 1);
        check("R7", "vec nested", vec_idx, 1);
        pulse_ack();
        pulse_done();
        check("R7", "vec back to outer", vec_idx, 4);
        check("R7", "outer stall", stall, 0);
        check("R7", "outer ipl3", ipl3, 1);
        pulse_done();
        check("R5", "idle after nest", vec_idx, 0);
    endtask

    task automatic t_repeat();
        pulse_req(4'b0100);
        pulse_req(4'b0100);
        check("R9", "no reset on repeat", rst_req, 0);
        check("R9", "vec unchanged", vec_idx, 3);
        pulse_ack();
        pulse_req(4'b0100);
        check("R9", "no reset repeat served", rst_req, 0);
        check("R9", "stall stays low", stall, 0);
        pulse_done();
        check("R9", "idle", vec_idx, 0);
    endtask

    task automatic t_stray();
        pulse_ack();
        pulse_done();
        check("R10", "vec idle", vec_idx, 0);
        check("R10", "ipl3 idle", ipl3, 0);
        check("R10", "stall idle", stall, 0);
        pulse_req(4'b0010);
        pulse_done();
        check("R10", "done while waiting", stall, 1);
        check("R10", "vec while waiting", vec_idx, 2);
        pulse_ack();
        pulse_done();
        check("R10", "idle after", vec_idx, 0);
    endtask

    task automatic t_conflict(int ph);
        pulse_req(4'b0010);
        if (ph >= 1) pulse_ack();
        if (ph >= 2) tick();
        pulse_req(4'b0100);
        check("R6", $sformatf("rst_req phase %0d", ph), rst_req, 1);
        check("R8", $sformatf("flag phase %0d", ph), conflict_flag, 1);
        tick(); tick();
        check("R6", "rst_req held", rst_req, 1);
        do_reset();
        check("R11", "rst_req cleared", rst_req, 0);
        check("R11", "vec cleared", vec_idx, 0);
        check("R8", "flag survives rst", conflict_flag, 1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        check("R8", "flag cleared", conflict_flag, 0);
    endtask

    task automatic t_flag_prio();
        pulse_req(4'b0001);
        trap_req = 4'b1000; flag_clr = 1'b1; tick();
        trap_req = '0; flag_clr = 1'b0;
        check("R8", "set beats clear", conflict_flag, 1);
        do_reset();
        por = 1'b1; tick(); por = 1'b0;
        check("R8", "por clears flag", conflict_flag, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        for (int i = 0; i < N; i++) t_single(i);
        t_priority();
        t_nest();
        t_repeat();
        t_stray();
        for (int p = 0; p < 3; p++) t_conflict(p);
        t_flag_prio();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule